// File: doc/BRIEF.md
# Memory Write Error Injection Matcher

This block sits in the write path of a memory controller and lets test software corrupt the check bits of chosen writes on purpose. Software describes a target location by DIMM (numbered within its channel), rank, channel, bank, page and column. Any of those fields can be left as "don't care". It also picks a corruption mask, which ECC half or halves to hit, and whether to flip ECC bits, parity bits or both. It then arms the injector.

Each write beat passes through the block with one register stage of latency. When an armed injector sees a write whose address meets every non-wildcard field, it XORs the mask into the check bits of the selected half or halves, flips the parity bit of those halves, or does both. In one-shot mode the injector disarms itself after the first corrupted write. In repeat mode it corrupts every matching write until software disarms it. All configuration sits behind a small register bus, and every register can be read back.

Top module: `mem_err_inject`

## Requirements
- R1: After reset every address field is a wildcard with value 0, and mask, section, type and enable read 0. Writes pass through unchanged.
- R2: With no wildcards, a write is corrupted only when all six address fields equal their programmed values. A difference in any one field leaves the write clean.
- R3: Setting the wildcard bit of a field removes that field from the comparison. The other fields are not affected.
- R4: The section code selects the target: bit 0 of the code is the low ECC half (check bits [7:0]), and bit 1 is the high half (check bits [15:8]). Code 3 hits both halves and code 0 hits neither. When the ECC type bit is set, the mask is XORed into each selected half.
- R5: When the parity type bit is set, the parity bit of each selected half is inverted. Parity bit 0 belongs to the low half and parity bit 1 to the high half.
- R6: ECC and parity corruption can be applied together. With neither type bit set, a match leaves data, check bits and parity untouched.
- R7: Writing any nonzero value to the enable register arms injection, and the register then reads 1. Writing 0 disarms it. A disarmed injector never corrupts.
- R8: With type bit 0 (repeat) clear, the first corrupted write clears the enable register. Later matching writes pass clean.
- R9: With the repeat bit set, every matching write is corrupted and the enable stays 1 until software writes 0.
- R10: Register map (16-bit data, read data one cycle after the address): 0 DIMM, 1 rank, 2 channel, 3 bank, 4 page, 5 column. Each of these holds the value in the low bits, limited to the field width, and the wildcard flag in bit 15. The other registers are 6 mask [7:0], 7 section [1:0], 8 type [2:0] (bit 0 repeat, bit 1 ECC, bit 2 parity) and 9 enable [0]. Unmapped addresses read 0.
- R11: Every write beat appears on the output one cycle later with the same valid and data.
- R12: A cycle with the write valid low corrupts nothing and does not use up a one-shot. A non-matching write does not use it up either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| wr_valid | input | 1 | Write beat valid |
| wr_dimm | input | 2 | DIMM index within its channel |
| wr_rank | input | 2 | Rank |
| wr_chan | input | 2 | Channel |
| wr_bank | input | 3 | Bank |
| wr_page | input | 6 | Page (row) |
| wr_col | input | 5 | Column |
| wr_data | input | 32 | Write data |
| wr_ecc | input | 16 | Check bits, two halves |
| wr_par | input | 2 | Parity bits, one per half |
| out_valid | output | 1 | Beat valid toward the array |
| out_data | output | 32 | Data toward the array |
| out_ecc | output | 16 | Possibly corrupted check bits |
| out_par | output | 2 | Possibly corrupted parity bits |

## Verification
The main sweep covers all 64 wildcard combinations. For each one it sends the exact target address and six addresses that each differ in a single field, so it can tell a field that is really compared from one that is ignored, and catch any field that leaks into another. A second sweep crosses the four section codes with the four ECC/parity type combinations. It shows which half and which kind of bit each setting reaches. One-shot and repeat runs read back the enable between writes, which separates a self-clearing injector from one that stays armed. Idle cycles and non-matching writes are placed between armed writes to show that only a real corrupted write consumes a one-shot.

// File: rtl/einj_pkg.sv
package einj_pkg;
  localparam int NF = 6;  // number of address match fields
  localparam int AW = 4;  // register address width

  typedef enum logic [AW-1:0] {
    RA_DIMM = 4'd0,
    RA_RANK = 4'd1,
    RA_CHAN = 4'd2,
    RA_BANK = 4'd3,
    RA_PAGE = 4'd4,
    RA_COL  = 4'd5,
    RA_MASK = 4'd6,
    RA_SECT = 4'd7,
    RA_TYPE = 4'd8,
    RA_EN   = 4'd9
  } reg_addr_e;

  localparam int TY_REPEAT = 0;
  localparam int TY_ECC    = 1;
  localparam int TY_PAR    = 2;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/einj_regs.sv
module einj_regs
  import einj_pkg::*;
#(
  parameter int FW     = 6,
  parameter int HALF_W = 8,
  parameter int REG_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [REG_W-1:0]       wdata,
  input  logic [NF-1:0][FW-1:0]  fmask,
  input  logic                   hit_i,
  output logic [NF-1:0][FW-1:0]  val_o,
  output logic [NF-1:0]          any_o,
  output logic [HALF_W-1:0]      mask_o,
  output logic [1:0]             sect_o,
  output logic [2:0]             type_o,
  output logic                   en_o,
  output logic [REG_W-1:0]       rdata_o
);
  logic [FW-1:0]     val_q [NF];
  logic              any_q [NF];
  logic [HALF_W-1:0] mask_q;
  logic [1:0]        sect_q;
  logic [2:0]        type_q;
  logic              en_q;
  logic              en_wr;
  logic [REG_W-1:0]  rd_c;

  assign en_wr = we && (addr == RA_EN);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[i] <= '0;
        any_q[i] <= 1'b1;
      end else if (we && addr == AW'(i)) begin
        val_q[i] <= wdata[FW-1:0] & fmask[i];
        any_q[i] <= wdata[REG_W-1];
      end
    end
    assign val_o[i] = val_q[i];
    assign any_o[i] = any_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      sect_q <= '0;
      type_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (we && addr == RA_MASK) mask_q <= wdata[HALF_W-1:0];
      if (we && addr == RA_SECT) sect_q <= wdata[1:0];
      if (we && addr == RA_TYPE) type_q <= wdata[2:0];
      if (en_wr)                               en_q <= |wdata;
      else if (hit_i && !type_q[TY_REPEAT])    en_q <= 1'b0;
    end
  end

  always_comb begin
    rd_c = '0;
    for (int i = 0; i < NF; i++) begin
      if (addr == AW'(i)) begin
        rd_c[FW-1:0]    = val_q[i];
        rd_c[REG_W-1]   = any_q[i];
      end
    end
    case (addr)
      RA_MASK: rd_c[HALF_W-1:0] = mask_q;
      RA_SECT: rd_c[1:0]        = sect_q;
      RA_TYPE: rd_c[2:0]        = type_q;
      RA_EN:   rd_c[0]          = en_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_c;
  end

  assign mask_o = mask_q;
  assign sect_o = sect_q;
  assign type_o = type_q;
  assign en_o   = en_q;

  AST_RESET_WILD: assert property (@(posedge clk)
    rst |=> ((&any_o) && !en_o && type_o == 3'b000)); // R1

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !type_o[TY_REPEAT] && !en_wr) |=> !en_o); // R8

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_o && type_o[TY_REPEAT] && !we) |=> en_o); // R9
endmodule

// File: rtl/einj_match.sv
module einj_match
  import einj_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic [NF-1:0][FW-1:0] addr_f,
  input  logic [NF-1:0][FW-1:0] val_f,
  input  logic [NF-1:0]         any_f,
  output logic                  match
);
  logic [NF-1:0] fld_ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign fld_ok[i] = any_f[i] || (addr_f[i] == val_f[i]);
  end

  assign match = &fld_ok;
endmodule

// File: rtl/einj_apply.sv
module einj_apply #(
  parameter int HALF_W = 8
) (
  input  logic                hit,
  input  logic [1:0]          sect,
  input  logic                ecc_en,
  input  logic                par_en,
  input  logic [HALF_W-1:0]   mask,
  input  logic [2*HALF_W-1:0] ecc_in,
  input  logic [1:0]          par_in,
  output logic [2*HALF_W-1:0] ecc_out,
  output logic [1:0]          par_out
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    assign sel = hit && sect[h];
    assign ecc_out[h*HALF_W +: HALF_W] =
      ecc_in[h*HALF_W +: HALF_W] ^ ((sel && ecc_en) ? mask : '0);
    assign par_out[h] = par_in[h] ^ (sel && par_en);
  end
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import einj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 6,
  parameter int COL_W  = 5,
  parameter int HALF_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                wr_valid,
  input  logic [DIMM_W-1:0]   wr_dimm,
  input  logic [RANK_W-1:0]   wr_rank,
  input  logic [CHAN_W-1:0]   wr_chan,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic [PAGE_W-1:0]   wr_page,
  input  logic [COL_W-1:0]    wr_col,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [2*HALF_W-1:0] wr_ecc,
  input  logic [1:0]          wr_par,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [2*HALF_W-1:0] out_ecc,
  output logic [1:0]          out_par
);
  localparam int FW = max_of(max_of(max_of(DIMM_W, RANK_W), max_of(CHAN_W, BANK_W)),
                             max_of(PAGE_W, COL_W));
  localparam int FWID [NF] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

  logic [NF-1:0][FW-1:0] fmask, addr_f, val_f;
  logic [NF-1:0]         any_f;
  logic [HALF_W-1:0]     mask;
  logic [1:0]            sect;
  logic [2:0]            typ;
  logic                  en, match, hit;
  logic [2*HALF_W-1:0]   ecc_x;
  logic [1:0]            par_x;

  for (genvar i = 0; i < NF; i++) begin : g_fmask
    assign fmask[i] = ~(~FW'(0) << FWID[i]);
  end

  assign addr_f[0] = FW'(wr_dimm);
  assign addr_f[1] = FW'(wr_rank);
  assign addr_f[2] = FW'(wr_chan);
  assign addr_f[3] = FW'(wr_bank);
  assign addr_f[4] = FW'(wr_page);
  assign addr_f[5] = FW'(wr_col);

  einj_regs #(.FW(FW), .HALF_W(HALF_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .fmask(fmask), .hit_i(hit), .val_o(val_f), .any_o(any_f), .mask_o(mask),
    .sect_o(sect), .type_o(typ), .en_o(en), .rdata_o(reg_rdata)
  );

  einj_match #(.FW(FW)) u_match (
    .addr_f(addr_f), .val_f(val_f), .any_f(any_f), .match(match)
  );

  assign hit = wr_valid && en && match && (typ[TY_ECC] || typ[TY_PAR]) && (sect != 2'b00);

  einj_apply #(.HALF_W(HALF_W)) u_apply (
    .hit(hit), .sect(sect), .ecc_en(typ[TY_ECC]), .par_en(typ[TY_PAR]),
    .mask(mask), .ecc_in(wr_ecc), .par_in(wr_par), .ecc_out(ecc_x), .par_out(par_x)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ecc   <= '0;
      out_par   <= '0;
    end else begin
      out_valid <= wr_valid;
      out_data  <= wr_data;
      out_ecc   <= ecc_x;
      out_par   <= par_x;
    end
  end

  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(wr_valid))); // R11

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> (out_data == $past(wr_data))); // R11

  AST_NO_HIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (out_ecc == $past(wr_ecc) && out_par == $past(wr_par))); // R6

  AST_HIGH_HALF_SPARED: assert property (@(posedge clk) disable iff (rst)
    (sect == 2'b01) |=> (out_ecc[2*HALF_W-1:HALF_W] == $past(wr_ecc[2*HALF_W-1:HALF_W]))); // R4
endmodule

// File: tb/tb_mem_err_inject.sv
module tb_mem_err_inject;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_dimm = '0, wr_rank = '0, wr_chan = '0;
  logic [2:0]  wr_bank = '0;
  logic [5:0]  wr_page = '0;
  logic [4:0]  wr_col = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] wr_ecc = '0;
  logic [1:0]  wr_par = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [15:0] out_ecc;
  logic [1:0]  out_par;

  int n_tests = 0, n_fail = 0;
  int fwid [6] = '{2, 2, 2, 3, 6, 5};
  int base [6] = '{2, 1, 3, 5, 37, 19};
  int cur  [6];
  bit sh_any [6];
  int sh_val [6];
  int sh_mask, sh_sect, sh_type;
  bit sh_en;

  mem_err_inject dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wr_valid(wr_valid), .wr_dimm(wr_dimm), .wr_rank(wr_rank),
    .wr_chan(wr_chan), .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
    .wr_data(wr_data), .wr_ecc(wr_ecc), .wr_par(wr_par), .out_valid(out_valid),
    .out_data(out_data), .out_ecc(out_ecc), .out_par(out_par)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a < 6) begin
      sh_any[a] = d[15];
      sh_val[a] = d & ((1 << fwid[a]) - 1);
    end else if (a == 6) sh_mask = d & 8'hFF;
    else if (a == 7) sh_sect = d & 3;
    else if (a == 8) sh_type = d & 7;
    else if (a == 9) sh_en = ((d & 16'hFFFF) != 0);
  endtask

  task automatic reg_read(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = 4'(a);
    @(posedge clk); #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic bit exp_hit();
    bit m = 1'b1;
    for (int i = 0; i < 6; i++) if (!sh_any[i] && cur[i] != sh_val[i]) m = 1'b0;
    return sh_en && m && (sh_type[1] || sh_type[2]) && (sh_sect != 0);
  endfunction

  task automatic xfer(input logic [15:0] ecc, input logic [1:0] par,
                      input logic [31:0] data, input string tag);
    bit h;
    logic [15:0] e_ecc;
    logic [1:0]  e_par;
    h = exp_hit();
    e_ecc = ecc; e_par = par;
    for (int k = 0; k < 2; k++) begin
      if (h && sh_sect[k]) begin
        if (sh_type[1]) e_ecc[k*8 +: 8] = e_ecc[k*8 +: 8] ^ 8'(sh_mask);
        if (sh_type[2]) e_par[k] = ~e_par[k];
      end
    end
    @(negedge clk);
    wr_valid = 1'b1;
    wr_dimm = 2'(cur[0]); wr_rank = 2'(cur[1]); wr_chan = 2'(cur[2]);
    wr_bank = 3'(cur[3]); wr_page = 6'(cur[4]); wr_col = 5'(cur[5]);
    wr_data = data; wr_ecc = ecc; wr_par = par;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    chk(tag, {13'd0, out_valid, out_par, out_ecc, out_data},
             {13'd0, 1'b1, e_par, e_ecc, data});
    if (h && !sh_type[0]) sh_en = 1'b0;
  endtask

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_dimm = 2'(cur[0]); wr_rank = 2'(cur[1]); wr_chan = 2'(cur[2]);
    wr_bank = 3'(cur[3]); wr_page = 6'(cur[4]); wr_col = 5'(cur[5]);
    wr_ecc = 16'hFFFF;
    @(posedge clk); #1;
    chk(tag, 64'(out_valid), 64'd0);
  endtask

  task automatic set_exact();
    for (int i = 0; i < 6; i++) begin
      cfg_write(i, base[i]);
      cur[i] = base[i];
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin sh_any[i] = 1'b1; sh_val[i] = 0; cur[i] = base[i]; end
    sh_mask = 0; sh_sect = 0; sh_type = 0; sh_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset values and clean pass-through
    for (int a = 0; a < 10; a++) reg_read(a, (a < 6) ? 16'h8000 : 0, "R1");
    xfer(16'hBEEF, 2'b01, 32'h1234_5678, "R1");

    // R10: register map, field width limiting, unmapped address
    cfg_write(0, 16'h80FF); reg_read(0, 16'h8003, "R10");
    cfg_write(3, 16'h00FF); reg_read(3, 16'h0007, "R10");
    cfg_write(4, 16'h7FFF); reg_read(4, 16'h003F, "R10");
    cfg_write(6, 16'hFF5A); reg_read(6, 16'h005A, "R10");
    cfg_write(7, 16'hFFFE); reg_read(7, 16'h0002, "R10");
    cfg_write(8, 16'hFFFD); reg_read(8, 16'h0005, "R10");
    reg_read(15, 0, "R10");
    cfg_write(9, 0); cfg_write(8, 0);

    // R2 / R3: all wildcard patterns, exact and single-field misses
    cfg_write(6, 8'hA5); cfg_write(7, 3); cfg_write(8, 3); cfg_write(9, 1);
    for (int wc = 0; wc < 64; wc++) begin
      for (int i = 0; i < 6; i++) cfg_write(i, (((wc >> i) & 1) << 15) | base[i]);
      for (int v = 0; v < 7; v++) begin
        for (int i = 0; i < 6; i++) cur[i] = base[i] ^ ((v == i + 1) ? 1 : 0);
        xfer(16'(wc * 37 + v * 911), 2'(v), 32'(wc * 131 + v), (wc == 0) ? "R2" : "R3");
      end
    end

    // R4 / R5 / R6: section code crossed with type bits
    set_exact();
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        cfg_write(7, s);
        cfg_write(8, ((t >> 1) << 2) | ((t & 1) << 1) | 1);
        xfer(16'h3C5A, 2'b10, 32'(s * 4 + t),
             (t == 0 || t == 3) ? "R6" : (t == 2) ? "R5" : "R4");
      end
    end

    // R7: enable arming by any nonzero value
    cfg_write(7, 3); cfg_write(8, 3); cfg_write(9, 0);
    xfer(16'h0F0F, 2'b00, 32'hA1, "R7");
    cfg_write(9, 16'h0100);
    reg_read(9, 1, "R7");
    xfer(16'h0F0F, 2'b00, 32'hA2, "R7");

    // R8: one-shot disarms after first injection
    cfg_write(8, 2); cfg_write(9, 1);
    xfer(16'h1111, 2'b11, 32'hB1, "R8");
    reg_read(9, 0, "R8");
    xfer(16'h1111, 2'b11, 32'hB2, "R8");

    // R12: idle cycles and misses do not consume a one-shot
    cfg_write(9, 1);
    idle_cycle("R12");
    cur[3] = base[3] ^ 1;
    xfer(16'h2222, 2'b01, 32'hC1, "R12");
    cur[3] = base[3];
    reg_read(9, 1, "R12");
    xfer(16'h2222, 2'b01, 32'hC2, "R12");
    reg_read(9, 0, "R12");

    // R9: repeat keeps corrupting until disarmed
    cfg_write(8, 7); cfg_write(9, 1);
    for (int k = 0; k < 4; k++) xfer(16'(k * 4097), 2'(k), 32'(k), "R9");
    reg_read(9, 1, "R9");
    cfg_write(9, 0);
    xfer(16'h5555, 2'b10, 32'hD0, "R9");

    // R11: valid drops when no beat is offered
    idle_cycle("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule